// File: doc/BRIEF.md
# Serializer with Symbol-Spaced Pre-Emphasis Drive Code

This block turns a 10-bit parallel symbol into a serial bit stream, one bit per bit clock, least significant bit first. Beside the serial bit it produces a signed drive code that models a current-steering line driver. A main tap sets the sign of the current bit. Up to two emphasis taps, each one tenth of the main tap, push the opposite way, and they act on the bit sent one bit period earlier. The result is a two-tap FIR pre-emphasis of 0%, 10% or 20%.

The word source pulses `load` for one bit clock every ten bit clocks, so the next symbol follows the last bit of the previous one with no gap. The emphasis setting is captured only at a load. A change made in the middle of a symbol therefore never alters the drive of that symbol. The drive code is in units of 10% of the main current. An analog driver stage, or a channel model downstream, uses it directly.

Top module: `ser_fir_tx`

## Requirements
- R1: From reset until the first bit-clock edge at which `load` is high, `ser_bit` is 0 and `drive_code` is 0.
- R2: On a bit-clock edge with `load` high, the word is captured. Bit k of the word (k = 0 for the LSB) is on `ser_bit` during the k-th bit clock after that edge, counting the clock that begins at the edge as k = 0.
- R3: When `load` is pulsed every 10 bit clocks, consecutive words appear on `ser_bit` back to back, with no idle bit between them.
- R4: With both emphasis taps off, `drive_code` is +10 while `ser_bit` is 1 and -10 while `ser_bit` is 0.
- R5: `emph_en[0]` and `emph_en[1]` each switch one tap on independently. Each tap that is on adds -1 to `drive_code` if the previous serial bit was 1, and +1 if it was 0. The total emphasis is 0, 1 or 2 units.
- R6: For the first bit after reset, the previous serial bit is taken as 0.
- R7: `emph_en` is sampled only on edges where `load` is high. Changes at other times have no effect on `drive_code` until the next load.
- R8: When a word has been fully sent and no new load arrives, `ser_bit` is 0. `drive_code` then keeps following R4 and R5 for a stream of zeros.
- R9: A load that arrives before a word is finished discards the rest of that word. The new word's LSB goes out in the next bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 10 | Parallel symbol |
| load | input | 1 | Capture `word_in` and `emph_en` at this edge |
| emph_en | input | 2 | One enable per emphasis tap |
| ser_bit | output | 1 | Serial output bit |
| drive_code | output | 5 | Signed drive level, units of 10% of the main tap |

## Verification
The assertions check several properties on every cycle:
- the output stays quiet before the first load;
- the sign of the drive matches the serial bit;
- the drive magnitude stays inside the main tap plus or minus the total tap weight;
- the LSB appears the cycle after a load;
- the first bit after reset sees a zero history;
- the drive holds steady while the bit and its history repeat inside a word.

Only the bench's scenarios can show the remaining behaviour. That covers the exact bit order across back-to-back words and every enable pattern. It also covers enable changes in the middle of a symbol, the zero stream after an exhausted word, and an early load that cuts a symbol short. The bench compares these against its own bit-queue model on every clock.

// File: rtl/ser_fir_pkg.sv
package ser_fir_pkg;
   // contribution of one emphasis tap, opposite in sign to the delayed bit
   function automatic int tap_term(input logic delayed_bit, input int unit);
      return delayed_bit ? -unit : unit;
   endfunction

   function automatic int main_term(input logic bit_now, input int unit);
      return bit_now ? unit : -unit;
   endfunction
endpackage

// File: rtl/ser_fir_shifter.sv
module ser_fir_shifter #(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic              cur_bit,
   output logic              prev_bit,
   output logic              active
);
   localparam int REST_W = WORD_W - 1;

   logic [REST_W-1:0] rest_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_bit  <= 1'b0;
         prev_bit <= 1'b0;
         rest_q   <= '0;
         active   <= 1'b0;
      end else begin
         prev_bit <= cur_bit;
         if (load) begin
            cur_bit <= word[0];
            rest_q  <= word[WORD_W-1:1];
            active  <= 1'b1;
         end else begin
            cur_bit <= rest_q[0];
            rest_q  <= {1'b0, rest_q[REST_W-1:1]};
         end
      end
   end
endmodule

// File: rtl/ser_fir_taps.sv
module ser_fir_taps
   import ser_fir_pkg::*;
#(
   parameter int NTAPS    = 2,
   parameter int MAIN_LVL = 10,
   parameter int TAP_LVL  = 1,
   parameter int DRIVE_W  = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [NTAPS-1:0]          emph_en,
   input  logic                      cur_bit,
   input  logic                      prev_bit,
   input  logic                      active,
   output logic signed [DRIVE_W-1:0] drive
);
   logic [NTAPS-1:0] en_q;
   int               contrib [NTAPS];
   int               total;

   // enables are held for a whole symbol
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= '0;
      else if (load) en_q <= emph_en;
   end

   for (genvar t = 0; t < NTAPS; t++) begin : g_tap
      always_comb contrib[t] = en_q[t] ? tap_term(prev_bit, TAP_LVL) : 0;
   end

   always_comb begin
      total = main_term(cur_bit, MAIN_LVL);
      for (int t = 0; t < NTAPS; t++) total += contrib[t];
      drive = active ? DRIVE_W'(total) : '0;
   end
endmodule

// File: rtl/ser_fir_tx.sv
module ser_fir_tx #(
   parameter int WORD_W   = 10,
   parameter int NTAPS    = 2,
   parameter int MAIN_LVL = 10,
   parameter int TAP_LVL  = 1,
   parameter int DRIVE_W  = $clog2(MAIN_LVL + NTAPS*TAP_LVL + 1) + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORD_W-1:0]         word_in,
   input  logic                      load,
   input  logic [NTAPS-1:0]          emph_en,
   output logic                      ser_bit,
   output logic signed [DRIVE_W-1:0] drive_code
);
   localparam int PEAK = MAIN_LVL + NTAPS*TAP_LVL;

   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (NTAPS < 1) begin : g_bad_taps
      $error("NTAPS must be at least 1");
   end
   if (NTAPS*TAP_LVL >= MAIN_LVL) begin : g_bad_ratio
      $error("total tap weight must stay below the main tap");
   end
   if (PEAK >= (1 << (DRIVE_W-1))) begin : g_bad_width
      $error("DRIVE_W too narrow for the peak drive");
   end

   logic cur_bit, prev_bit, active;

   ser_fir_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .word(word_in),
      .cur_bit(cur_bit), .prev_bit(prev_bit), .active(active));

   ser_fir_taps #(.NTAPS(NTAPS), .MAIN_LVL(MAIN_LVL), .TAP_LVL(TAP_LVL),
                  .DRIVE_W(DRIVE_W)) u_taps (
      .clk(clk), .rst_n(rst_n), .load(load), .emph_en(emph_en),
      .cur_bit(cur_bit), .prev_bit(prev_bit), .active(active),
      .drive(drive_code));

   assign ser_bit = cur_bit;
endmodule

// File: rtl/ser_fir_tx_chk.sv
module ser_fir_tx_chk #(
   parameter int WORD_W   = 10,
   parameter int NTAPS    = 2,
   parameter int MAIN_LVL = 10,
   parameter int TAP_LVL  = 1,
   parameter int DRIVE_W  = 5
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [WORD_W-1:0]         word_in,
   input logic                      load,
   input logic [NTAPS-1:0]          emph_en,
   input logic                      ser_bit,
   input logic signed [DRIVE_W-1:0] drive_code
);
   logic seen, seen_d;
   int   dval, mag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= 1'b0;
         seen_d <= 1'b0;
      end else begin
         seen   <= seen | load;
         seen_d <= seen;
      end
   end

   always_comb begin
      dval = int'(drive_code);
      mag  = (dval < 0) ? -dval : dval;
   end

   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (!ser_bit && dval == 0));

   p_lsb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> ser_bit == $past(word_in[0]));

   p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (ser_bit ? dval > 0 : dval < 0));

   p_mag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (mag >= MAIN_LVL - NTAPS*TAP_LVL && mag <= MAIN_LVL + NTAPS*TAP_LVL));

   p_first_hist_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load) && !$past(seen)) |->
         dval == (ser_bit ? MAIN_LVL : -MAIN_LVL) + TAP_LVL*$countones($past(emph_en)));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_d && !$past(load) && ser_bit == $past(ser_bit) &&
       $past(ser_bit) == $past(ser_bit, 2)) |-> $stable(drive_code));
endmodule

bind ser_fir_tx ser_fir_tx_chk #(.WORD_W(WORD_W), .NTAPS(NTAPS), .MAIN_LVL(MAIN_LVL),
                                 .TAP_LVL(TAP_LVL), .DRIVE_W(DRIVE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .word_in(word_in), .load(load), .emph_en(emph_en),
   .ser_bit(ser_bit), .drive_code(drive_code));

// File: tb/sim_ser_fir_tx.sv
`timescale 1ns/1ps
module sim_ser_fir_tx;
   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [9:0]       word_in = '0;
   logic             load = 1'b0;
   logic [1:0]       emph_en = '0;
   logic             ser_bit;
   logic signed [4:0] drive_code;

   int checks = 0;
   int errors = 0;
   string phase = "R1";

   // behavioural model
   bit  bitq [$];
   int  m_cur = 0, m_prev = 0, m_act = 0;
   logic [1:0] m_en = '0;

   always #2.5 clk = ~clk;

   ser_fir_tx u0 (.clk(clk), .rst_n(rst_n), .word_in(word_in), .load(load),
                  .emph_en(emph_en), .ser_bit(ser_bit), .drive_code(drive_code));

   function automatic int exp_drive();
      int d;
      if (m_act == 0) return 0;
      d = (m_cur != 0) ? 10 : -10;
      d += (m_en[0] + m_en[1]) * ((m_prev != 0) ? -1 : 1);
      return d;
   endfunction

   task automatic compare();
      int ed;
      ed = exp_drive();
      checks++;
      if (ser_bit !== 1'(m_cur)) begin
         errors++;
         $display("FAIL %s ser_bit actual %0b expected %0d", phase, ser_bit, m_cur);
      end
      checks++;
      if (int'(drive_code) != ed) begin
         errors++;
         $display("FAIL %s drive_code actual %0d expected %0d", phase, drive_code, ed);
      end
   endtask

   // drive inputs at negedge, model updates at posedge, compare at next negedge
   task automatic step(input logic ld, input logic [9:0] w, input logic [1:0] en);
      load = ld; word_in = w; emph_en = en;
      @(posedge clk);
      m_prev = m_cur;
      if (ld) begin
         bitq.delete();
         for (int k = 0; k < 10; k++) bitq.push_back(w[k]);
         m_act = 1;
         m_en  = en;
      end
      m_cur = (bitq.size() > 0) ? int'(bitq.pop_front()) : 0;
      @(negedge clk);
      compare();
   endtask

   task automatic send_word(input logic [9:0] w, input logic [1:0] en);
      step(1'b1, w, en);
      for (int k = 1; k < 10; k++) step(1'b0, 10'h0, en);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare();                       // R1 during reset
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) step(1'b0, 10'h3FF, 2'b11);   // R1 idle, inputs ignored
      // R6: first bit 1, both taps, zero history -> 12
      phase = "R6";
      step(1'b1, 10'h001, 2'b11);
      checks++;
      if (int'(drive_code) != 12) begin
         errors++;
         $display("FAIL R6 first drive actual %0d expected 12", drive_code);
      end
      for (int k = 1; k < 10; k++) step(1'b0, 10'h0, 2'b11);
      phase = "R2";  send_word(10'h2D3, 2'b00);
      phase = "R3";  send_word(10'h155, 2'b00);
      phase = "R4";  send_word(10'h0F0, 2'b00);
      phase = "R5";  send_word(10'h2AA, 2'b01);
      phase = "R5";  send_word(10'h1C7, 2'b10);
      phase = "R5";  send_word(10'h333, 2'b11);
      // R7: enable toggles mid-word must not matter
      phase = "R7";
      step(1'b1, 10'h25A, 2'b00);
      for (int k = 1; k < 10; k++) step(1'b0, 10'h0, 2'(k));
      phase = "R7";  send_word(10'h3C1, 2'b11);
      // R8: no reload, zero stream
      phase = "R8";
      for (int k = 0; k < 6; k++) step(1'b0, 10'h3FF, 2'b00);
      // R9: early load after 4 bits
      phase = "R9";
      step(1'b1, 10'h3FF, 2'b01);
      for (int k = 1; k < 4; k++) step(1'b0, 10'h0, 2'b01);
      send_word(10'h001, 2'b10);
      for (int k = 0; k < 3; k++) step(1'b0, 10'h0, 2'b00);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule